// File: doc/BRIEF.md
# Parallel Port Strobe Timing Generator

This block places one byte on a printer-style parallel port and produces the data strobe around it, with both the data-to-strobe setup time and the strobe pulse width programmed in cycles of the system clock. A host-side stream hands over bytes with a valid/ready handshake. When a byte is accepted, the block drives it onto the port data pins and waits out the setup time. It then raises the strobe for the programmed width and drops it. It then waits until the peripheral has pulsed its acknowledge input and released its busy input. Only then does it return to idle and accept the next byte.

The byte stream is back-pressured for the whole of a transfer. `byte_ready` is high only while the block is idle and not held in soft reset. A byte moves only in a cycle where `byte_valid` and `byte_ready` are both high at the rising clock edge. The source may hold `byte_valid` high with a stable byte for as long as it likes. The peripheral inputs `pp_busy` and `pp_ack` are asynchronous. They pass through a synchronizer of `SYNC_STAGES` flops before the control logic sees them.

The configuration word `cfg_word` holds three fields. Bits [6:0] give the setup count and bits [14:8] give the strobe width count. Bit 15 is a test enable that exposes the running tick counter on `dbg_count`. Bit 7 is unused. A separate `soft_rst` pin keeps the control logic in its idle state for as long as it is high.

Top module: `pstrobe_gen`

## Requirements
- R1: After `rst_n` is released, `idle` is 1, `pp_strobe` is 0, `byte_ready` is 1, `pp_data` is 0x00 and `dbg_count` is 0.
- R2: `byte_ready` is 1 only while idle and not in soft reset. A byte is accepted at a rising edge where `byte_valid` and `byte_ready` are both 1, and `byte_ready` stays 0 until that transfer has completed.
- R3: After a byte is accepted, `pp_data` shows it from the next cycle on, and `pp_strobe` rises exactly N cycles later, where N is `cfg_word[6:0]`. A value of 0 gives N = 1.
- R4: `pp_strobe` (active high) stays 1 for exactly M cycles, where M is `cfg_word[14:8]`. A value of 0 gives M = 1.
- R5: `pp_data` does not change from the cycle after acceptance until the next byte is accepted, so it is stable through setup, strobe and release.
- R6: After the strobe falls, the block returns to idle only once a high level on the synchronized `pp_ack` has been seen and the synchronized `pp_busy` is low. If `pp_busy` stays high, or no acknowledge has arrived, the block keeps `idle` at 0.
- R7: While `soft_rst` is 1, the control logic is held idle: `pp_strobe` is 0, `idle` is 1 and `byte_ready` is 0, starting the cycle after `soft_rst` is sampled high and lasting until it is cleared. `byte_ready` returns to 1 once `soft_rst` is 0.
- R8: With `cfg_word[15]` = 1, `dbg_count` shows the tick counter. This equals N-1 in the first setup cycle. With `cfg_word[15]` = 0, `dbg_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick of timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Setup count [6:0], width count [14:8], test enable [15] |
| soft_rst | input | 1 | Holds control logic idle while 1 |
| byte_data | input | 8 | Byte to send |
| byte_valid | input | 1 | Source has a byte |
| byte_ready | output | 1 | Block can accept a byte |
| pp_busy | input | 1 | Peripheral busy, asynchronous |
| pp_ack | input | 1 | Peripheral acknowledge, asynchronous |
| pp_data | output | 8 | Port data pins |
| pp_strobe | output | 1 | Data strobe, active high |
| idle | output | 1 | Transfer state machine is idle |
| dbg_count | output | 7 | Tick counter in test mode, else 0 |

## Verification
The assertions assume that `cfg_word` does not change while a transfer is in flight. They also assume that each acknowledge pulse on `pp_ack` lasts longer than one clock, so that the synchronizer does not lose it. The bench changes the configuration only while the block is idle. It holds every acknowledge high for three cycles, and it drives the peripheral inputs on falling edges. A soft reset is applied only in a window where the byte monitor is switched off, so that no strobe the monitor expects is cut short.

// File: rtl/pstrobe_pkg.sv
package pstrobe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_WAIT   = 2'd3
  } pstrobe_state_e;
endpackage

// File: rtl/pstrobe_sync.sv
module pstrobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pstrobe_tick_cnt.sv
module pstrobe_tick_cnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // The counter only ever counts down or takes a fresh load
  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) && !$past(clr) && $past(cnt) != '0 |-> cnt == $past(cnt) - 1'b1); // R3
endmodule

// File: rtl/pstrobe_ctrl.sv
module pstrobe_ctrl
  import pstrobe_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [CNT_W-1:0] setup_cfg,
  input  logic [CNT_W-1:0] width_cfg,
  input  logic             go,
  input  logic             cnt_zero,
  input  logic             busy_s,
  input  logic             ack_s,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_load_val,
  output pstrobe_state_e   state,
  output logic             strobe
);
  pstrobe_state_e state_nx;
  logic           ack_seen;
  logic [CNT_W-1:0] setup_m1, width_m1;

  // A zero count is treated as a single tick
  assign setup_m1 = (setup_cfg == '0) ? '0 : setup_cfg - 1'b1;
  assign width_m1 = (width_cfg == '0) ? '0 : width_cfg - 1'b1;

  always_comb begin
    state_nx     = state;
    cnt_load     = 1'b0;
    cnt_load_val = '0;
    unique case (state)
      ST_IDLE: if (go) begin
        state_nx     = ST_SETUP;
        cnt_load     = 1'b1;
        cnt_load_val = setup_m1;
      end
      ST_SETUP: if (cnt_zero) begin
        state_nx     = ST_STROBE;
        cnt_load     = 1'b1;
        cnt_load_val = width_m1;
      end
      ST_STROBE: if (cnt_zero) state_nx = ST_WAIT;
      ST_WAIT:   if (ack_seen && !busy_s) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= ST_IDLE;
    else if (soft_rst) state <= ST_IDLE;
    else               state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ack_seen <= 1'b0;
    else if (soft_rst)               ack_seen <= 1'b0;
    else if (state == ST_IDLE)       ack_seen <= 1'b0;
    else if (state == ST_WAIT && ack_s) ack_seen <= 1'b1;
  end

  assign strobe = (state == ST_STROBE);

  AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(state) == ST_SETUP); // R3
  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state) == ST_WAIT && state == ST_IDLE && !$past(soft_rst) |-> $past(ack_seen) && !$past(busy_s)); // R6
  AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> state == ST_IDLE && !strobe); // R7
  AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    go && state == ST_IDLE && !soft_rst |=> state == ST_SETUP); // R2
endmodule

// File: rtl/pstrobe_gen.sv
module pstrobe_gen
  import pstrobe_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*CNT_W+1:0]   cfg_word,
  input  logic                 soft_rst,
  input  logic [DATA_W-1:0]    byte_data,
  input  logic                 byte_valid,
  output logic                 byte_ready,
  input  logic                 pp_busy,
  input  logic                 pp_ack,
  output logic [DATA_W-1:0]    pp_data,
  output logic                 pp_strobe,
  output logic                 idle,
  output logic [CNT_W-1:0]     dbg_count
);
  localparam int SETUP_LSB = 0;
  localparam int WIDTH_LSB = CNT_W + 1;
  localparam int TEST_BIT  = 2*CNT_W + 1;

  pstrobe_state_e   state;
  logic             busy_s, ack_s, cnt_zero, cnt_load, accept;
  logic [CNT_W-1:0] cnt, cnt_load_val;

  pstrobe_sync #(.STAGES(SYNC_STAGES)) u_sync_busy (
    .clk(clk), .rst_n(rst_n), .d_async(pp_busy), .q_sync(busy_s));
  pstrobe_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
    .clk(clk), .rst_n(rst_n), .d_async(pp_ack), .q_sync(ack_s));

  assign idle       = (state == ST_IDLE);
  assign byte_ready = idle && !soft_rst;
  assign accept     = byte_valid && byte_ready;

  pstrobe_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .setup_cfg(cfg_word[SETUP_LSB +: CNT_W]),
    .width_cfg(cfg_word[WIDTH_LSB +: CNT_W]),
    .go(accept), .cnt_zero(cnt_zero), .busy_s(busy_s), .ack_s(ack_s),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .state(state), .strobe(pp_strobe));

  pstrobe_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .load(cnt_load),
    .load_val(cnt_load_val), .cnt(cnt), .zero(cnt_zero));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pp_data <= '0;
    else if (accept) pp_data <= byte_data;
  end

  assign dbg_count = cfg_word[TEST_BIT] ? cnt : '0;

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> $stable(pp_data)); // R5
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pp_strobe |-> !byte_ready); // R2
endmodule

// File: tb/pstrobe_gen_tb.sv
module pstrobe_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        soft_rst = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        byte_valid = 1'b0;
  logic        byte_ready;
  logic        pp_busy = 1'b0;
  logic        pp_ack = 1'b0;
  logic [7:0]  pp_data;
  logic        pp_strobe;
  logic        idle;
  logic [6:0]  dbg_count;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b1;

  typedef struct { logic [7:0] d; int su; int wd; bit tst; } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  pstrobe_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .soft_rst(soft_rst),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .pp_busy(pp_busy), .pp_ack(pp_ack), .pp_data(pp_data),
    .pp_strobe(pp_strobe), .idle(idle), .dbg_count(dbg_count));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the expected item at each handshake and measures the port
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && byte_valid && byte_ready) begin
        exp_t e;
        int s, w;
        e = sb_q.pop_front();
        s = 0;
        @(negedge clk);
        if (e.tst) chk(dbg_count == 7'(e.su - 1), "R8 dbg count", dbg_count, e.su - 1);
        else       chk(dbg_count == 0, "R8 dbg off", dbg_count, 0);
        while (!pp_strobe && s < 400) begin s++; @(negedge clk); end
        chk(s == e.su, "R3 setup ticks", s, e.su);
        chk(pp_data == e.d, "R5 data at strobe", pp_data, e.d);
        chk(byte_ready == 1'b0, "R2 no ready in transfer", byte_ready, 0);
        w = 0;
        while (pp_strobe && w < 400) begin w++; @(negedge clk); end
        chk(w == e.wd, "R4 strobe width", w, e.wd);
        chk(pp_data == e.d, "R5 data after strobe", pp_data, e.d);
      end
    end
  end

  // Driver plus peripheral model; busy_first: busy drops before the ack
  task automatic xfer(input logic [7:0] d, input int su, input int wd, input bit tst,
                      input int hold, input bit busy_first);
    exp_t e;
    @(negedge clk);
    while (!byte_ready) @(negedge clk);
    cfg_word = {tst, 7'(wd), 1'b0, 7'(su)};
    e.d = d; e.su = (su == 0) ? 1 : su; e.wd = (wd == 0) ? 1 : wd; e.tst = tst;
    sb_q.push_back(e);
    byte_data = d; byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0; byte_data = ~d;
    while (!pp_strobe) @(negedge clk);
    pp_busy = 1'b1;
    while (pp_strobe) @(negedge clk);
    if (busy_first) begin
      pp_busy = 1'b0;
      repeat (hold) @(negedge clk);
      chk(idle == 1'b0, "R6 waits for ack", idle, 0);
      pp_ack = 1'b1; repeat (3) @(negedge clk); pp_ack = 1'b0;
    end else begin
      pp_ack = 1'b1; repeat (3) @(negedge clk); pp_ack = 1'b0;
      repeat (hold) @(negedge clk);
      chk(idle == 1'b0, "R6 waits for busy low", idle, 0);
      pp_busy = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk(idle == 1'b1, "R6 returns idle", idle, 1);
    chk(pp_data == d, "R5 data held after done", pp_data, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle == 1'b1, "R1 idle", idle, 1);
    chk(pp_strobe == 1'b0, "R1 strobe", pp_strobe, 0);
    chk(byte_ready == 1'b1, "R1 ready", byte_ready, 1);
    chk(pp_data == 8'h00, "R1 data", pp_data, 0);
    chk(dbg_count == 0, "R1 dbg", dbg_count, 0);

    xfer(8'hA5, 3, 4, 1'b0, 10, 1'b0);
    xfer(8'h3C, 0, 0, 1'b0, 5, 1'b1);
    xfer(8'hF0, 1, 1, 1'b1, 8, 1'b0);
    xfer(8'h81, 9, 2, 1'b1, 12, 1'b1);
    xfer(8'h5A, 127, 127, 1'b0, 3, 1'b0);

    // R7: soft reset in the middle of a strobe
    mon_en = 1'b0;
    @(negedge clk);
    cfg_word = {1'b0, 7'd40, 1'b0, 7'd2};
    byte_data = 8'h77; byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
    while (!pp_strobe) @(negedge clk);
    soft_rst = 1'b1;
    chk(byte_ready == 1'b0, "R7 ready low at once", byte_ready, 0);
    @(negedge clk);
    chk(pp_strobe == 1'b0, "R7 strobe dropped", pp_strobe, 0);
    chk(idle == 1'b1, "R7 held idle", idle, 1);
    byte_valid = 1'b1; byte_data = 8'h11;
    repeat (5) @(negedge clk);
    chk(byte_ready == 1'b0, "R7 ready held low", byte_ready, 0);
    chk(pp_strobe == 1'b0, "R7 no strobe while held", pp_strobe, 0);
    chk(pp_data == 8'h77, "R7 byte not taken", pp_data, 8'h77);
    byte_valid = 1'b0;
    soft_rst = 1'b0;
    @(negedge clk);
    chk(byte_ready == 1'b1, "R7 ready back", byte_ready, 1);
    mon_en = 1'b1;

    xfer(8'hC3, 2, 5, 1'b0, 4, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule